// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Zero-Turnaround Read/Write Interleave

This block is a synthesizable, scaled-down model of a synchronous static RAM that takes a new read or write on every enabled clock edge. No idle cycle is needed when the bus changes direction. A read command loads the output register one enabled edge after it is sampled. The data for a write is taken from the data input two enabled edges after its command. Because both latencies line up, a write following a read, or a read following a write, never makes the two compete for the shared data slot.

Addresses come either from the external bus (load) or from an internal 2-bit burst counter (advance). The counter steps the two low address bits in interleaved or linear order. A clock enable freezes the whole pipeline. Three chip selects gate new operations, so several devices can share one bus. An asynchronous output enable and a sleep input control only whether the data is driven. A read that hits an address whose write is committing on the same edge returns the new bytes merged over the stored word.

Top module: `pipe_sram`

## Requirements
- R1: A selected read loaded at enabled edge k sets `rvalid_o` and presents the word from the array on `rdata_o` after enabled edge k+1. Both outputs are 0 after reset.
- R2: A selected write loaded at enabled edge k stores `wdata_i` as sampled at enabled edge k+2. Only the bytes flagged in `be_i` at edge k are stored, where `be_i[b]` covers bits `[9b+8:9b]`. A write never raises `rvalid_o`.
- R3: Reads and writes may alternate on consecutive enabled edges. A read of an address whose write commits on the read's array-access edge returns the enabled bytes of that write and the stored value for the other bytes.
- R4: An edge with `cke_i` low changes nothing. Outputs hold, no command or write data is taken, and pending operations wait for the next enabled edge.
- R5: A load starts an operation only when `cs0_ni`=0, `cs1_i`=1 and `cs2_ni`=0. Any other pattern is a deselect: `rvalid_o` is 0 after the following enabled edge, and no array word changes.
- R6: With `adv_i`=0 the external address is loaded and the burst counter cleared. With `adv_i`=1 the counter steps, and the cycle repeats the type of the burst's loading operation while ignoring `wr_i` and the chip selects. A burst whose load was a deselect stays deselected.
- R7: With `lin_i`=0 the n-th beat of a burst (n=0 at the load) uses low address bits `start XOR (n mod 4)`.
- R8: With `lin_i`=1 the n-th beat uses low address bits `(start + n) mod 4`. The upper address bits never change during a burst.
- R9: `dq_oe_o` is 1 only while `rvalid_o`, `oe_i`=1 and `sleep_i`=0 all hold, and it follows `oe_i` without a clock. `rdata_o` is 0 whenever `dq_oe_o` is 0. `oe_i` has no effect on the pipeline.
- R10: `sleep_i`=1 turns the drivers off at once. Every command sampled while it is high is a deselect and ends any burst. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable, active high |
| cs0_ni | input | 1 | Chip select, active low |
| cs1_i | input | 1 | Chip select, active high |
| cs2_ni | input | 1 | Chip select, active low |
| adv_i | input | 1 | 1: step burst counter, 0: load external address |
| wr_i | input | 1 | 1: write, 0: read (on load cycles) |
| be_i | input | NBYTES | Byte write enables for the command |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data, sampled two enabled edges after its command |
| lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_i | input | 1 | Asynchronous output enable |
| sleep_i | input | 1 | Asynchronous power-down |
| rdata_o | output | DATA_W | Read data, 0 when not driven |
| dq_oe_o | output | 1 | Data bus drive enable |
| rvalid_o | output | 1 | Registered read-data valid |

## Verification
On every cycle the assertions check the following: read and deselect latency, that writes and sleep-time commands never raise the valid output, that a suspended edge holds the valid output, and that output enable and sleep gate the drivers. Only the bench scenarios can show data correctness. These cover the stored word for every address, byte-merge on partial writes, and forwarding on back-to-back write/read pairs. They also cover the beat address sequence in both burst orders from every start offset, write data held back across suspended edges, and array contents kept through deselects and sleep.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_e;

  // low address bits of a burst beat
  function automatic logic [1:0] beat_ofs(input logic lin, input logic [1:0] start,
                                          input logic [1:0] n);
    return lin ? 2'(start + n) : (start ^ n);
  endfunction
endpackage

// File: rtl/psram_burst.sv
module psram_burst
  import psram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              sleep_i,
  input  logic              cs_ok_i,
  input  logic              adv_i,
  input  logic              wr_i,
  input  logic              lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  op_e               op_q;
  logic [1:0]        cnt_nxt;

  assign cnt_nxt = 2'(cnt_q + 2'd1);

  always_comb begin
    op_o   = OP_IDLE;
    addr_o = addr_i;
    if (!sleep_i) begin
      if (!adv_i) begin
        op_o = cs_ok_i ? (wr_i ? OP_WR : OP_RD) : OP_IDLE;
      end else begin
        op_o   = op_q;
        addr_o = {base_q[ADDR_W-1:2], beat_ofs(lin_i, base_q[1:0], cnt_nxt)};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (cke_i) begin
      if (sleep_i) begin
        op_q <= OP_IDLE;
      end else if (!adv_i) begin
        op_q   <= op_o;
        base_q <= addr_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9,
  localparam int DATA_W = NBYTES * BYTE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [NBYTES-1:0] wbe_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              fwd_hit;

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (wbe_i[b]) mem[waddr_i][b*BYTE_W +: BYTE_W] <= wdata_i[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign fwd_hit = we_i && (waddr_i == raddr_i);

  // committing write overrides its enabled bytes
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign rdata_o[b*BYTE_W +: BYTE_W] = (fwd_hit && wbe_i[b]) ? wdata_i[b*BYTE_W +: BYTE_W]
                                                               : mem[raddr_i][b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import psram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9,
  localparam int DATA_W = NBYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs0_ni,
  input  logic              cs1_i,
  input  logic              cs2_ni,
  input  logic              adv_i,
  input  logic              wr_i,
  input  logic [NBYTES-1:0] be_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lin_i,
  input  logic              oe_i,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dq_oe_o,
  output logic              rvalid_o
);
  op_e               cur_op, op1_q;
  logic [ADDR_W-1:0] cur_addr, addr1_q, addr2_q;
  logic [NBYTES-1:0] be1_q, be2_q;
  logic              wr2_q, rvld_q;
  logic [DATA_W-1:0] rdata_q, arr_rdata;
  logic              cs_ok;

  assign cs_ok = !cs0_ni && cs1_i && !cs2_ni;

  psram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cke_i   (cke_i),
    .sleep_i (sleep_i),
    .cs_ok_i (cs_ok),
    .adv_i   (adv_i),
    .wr_i    (wr_i),
    .lin_i   (lin_i),
    .addr_i  (addr_i),
    .op_o    (cur_op),
    .addr_o  (cur_addr)
  );

  psram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (cke_i && wr2_q),
    .waddr_i (addr2_q),
    .wbe_i   (be2_q),
    .wdata_i (wdata_i),
    .raddr_i (addr1_q),
    .rdata_o (arr_rdata)
  );

  // stage 1: command; stage 2: write waits for data; output register for reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op1_q   <= OP_IDLE;
      addr1_q <= '0;
      be1_q   <= '0;
      wr2_q   <= 1'b0;
      addr2_q <= '0;
      be2_q   <= '0;
      rvld_q  <= 1'b0;
      rdata_q <= '0;
    end else if (cke_i) begin
      op1_q   <= cur_op;
      addr1_q <= cur_addr;
      be1_q   <= be_i;
      wr2_q   <= (op1_q == OP_WR);
      addr2_q <= addr1_q;
      be2_q   <= be1_q;
      rvld_q  <= (op1_q == OP_RD);
      if (op1_q == OP_RD) rdata_q <= arr_rdata;
    end
  end

  assign rvalid_o = rvld_q;
  assign dq_oe_o  = rvld_q && oe_i && !sleep_i;
  assign rdata_o  = dq_oe_o ? rdata_q : '0;
endmodule

// File: rtl/psram_chk.sv
module psram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_i,
  input logic              cs0_ni,
  input logic              cs1_i,
  input logic              cs2_ni,
  input logic              adv_i,
  input logic              wr_i,
  input logic              oe_i,
  input logic              sleep_i,
  input logic              rvalid_o,
  input logic              dq_oe_o,
  input logic [DATA_W-1:0] rdata_o
);
  logic sel, ld_rd, ld_wr, ld_desel;

  assign sel      = !cs0_ni && cs1_i && !cs2_ni;
  assign ld_rd    = cke_i && !adv_i && !sleep_i && sel && !wr_i;
  assign ld_wr    = cke_i && !adv_i && !sleep_i && sel && wr_i;
  assign ld_desel = cke_i && !adv_i && !sel;

  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_rd ##1 cke_i |=> rvalid_o);  // R1
  AST_WR_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_wr ##1 cke_i |=> !rvalid_o);  // R2
  AST_SUSPEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> $stable(rvalid_o));  // R4
  AST_DESEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_desel ##1 cke_i |=> !rvalid_o);  // R5
  AST_OE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (!dq_oe_o && rdata_o == '0));  // R9
  AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (!dq_oe_o && rdata_o == '0));  // R10
  AST_SLEEP_NO_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && sleep_i) ##1 cke_i |=> !rvalid_o);  // R10
endmodule

bind pipe_sram psram_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_pipe_sram.sv
module sim_pipe_sram;
  localparam int AW = 8, NB = 4, BW = 9, DW = NB * BW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni, cke_i, cs0_ni, cs1_i, cs2_ni, adv_i, wr_i, lin_i, oe_i, sleep_i;
  logic [NB-1:0] be_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i, rdata_o;
  logic dq_oe_o, rvalid_o;

  pipe_sram u0 (.*, .clk_i(clk));

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] mdl [256];
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;
  int            b_op;
  int            ek [2];
  logic [AW-1:0] ea [2], wa [2];
  string         er [2];
  logic          wv [2];
  logic [NB-1:0] wb [2];
  logic [DW-1:0] wd [2];
  logic [DW-1:0] held_d;
  logic          held_v;

  task automatic chk(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    logic [7:0] x;
    x = 8'(a * 13 + k * 29);
    return {4'(a ^ k), x, x ^ 8'h3c, ~x, 8'(x + 8'd17)};
  endfunction

  // cs = {cs2_ni, cs1_i, cs0_ni}; 3'b010 selects
  task automatic tick(input bit adv, input bit wr, input bit [2:0] cs, input logic [AW-1:0] a,
                      input logic [NB-1:0] be, input logic [DW-1:0] d, input string r);
    int op;
    logic [AW-1:0] ad;
    @(negedge clk);
    if (ek[1] == 1) begin
      chk({er[1], " valid"}, DW'(rvalid_o), DW'(1));
      chk(er[1], rdata_o, mdl[ea[1]]);
    end else if (ek[1] == 0) begin
      chk({er[1], " idle"}, DW'(rvalid_o), DW'(0));
    end
    wdata_i = wv[1] ? wd[1] : '0;
    if (wv[1])
      for (int b = 0; b < NB; b++)
        if (wb[1][b]) mdl[wa[1]][b*BW +: BW] = wd[1][b*BW +: BW];
    ad = a;
    if (sleep_i) begin
      op = 0;
      b_op = 0;
    end else if (!adv) begin
      op = (cs == 3'b010) ? (wr ? 2 : 1) : 0;
      b_op = op;
      b_base = a;
      b_cnt = 2'd0;
    end else begin
      b_cnt = 2'(b_cnt + 2'd1);
      op = b_op;
      ad = {b_base[AW-1:2], lin_i ? 2'(b_base[1:0] + b_cnt) : (b_base[1:0] ^ b_cnt)};
    end
    ek[1] = ek[0]; ea[1] = ea[0]; er[1] = er[0];
    wv[1] = wv[0]; wa[1] = wa[0]; wb[1] = wb[0]; wd[1] = wd[0];
    ek[0] = (op == 1) ? 1 : 0; ea[0] = ad; er[0] = r;
    wv[0] = (op == 2); wa[0] = ad; wb[0] = be; wd[0] = d;
    cke_i = 1'b1; adv_i = adv; wr_i = wr; {cs2_ni, cs1_i, cs0_ni} = cs;
    addr_i = a; be_i = be;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 3'b111, '0, '0, '0, "R5 idle");
  endtask

  // suspended edges with hostile inputs; outputs must hold
  task automatic stall(input int n);
    @(negedge clk);
    held_d = rdata_o; held_v = rvalid_o;
    cke_i = 1'b0; adv_i = 1'b0; wr_i = 1'b1; {cs2_ni, cs1_i, cs0_ni} = 3'b010;
    be_i = '1; addr_i = 8'd10; wdata_i = {DW{1'b1}};
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R4 hold data", rdata_o, held_d);
      chk("R4 hold valid", DW'(rvalid_o), DW'(held_v));
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; cke_i = 1'b1; cs0_ni = 1'b1; cs1_i = 1'b0; cs2_ni = 1'b1;
    adv_i = 1'b0; wr_i = 1'b0; be_i = '0; addr_i = '0; wdata_i = '0;
    lin_i = 1'b0; oe_i = 1'b1; sleep_i = 1'b0;
    b_base = '0; b_cnt = '0; b_op = 0;
    for (int i = 0; i < 2; i++) begin
      ek[i] = -1; wv[i] = 1'b0; ea[i] = '0; wa[i] = '0; wb[i] = '0; wd[i] = '0; er[i] = "";
    end
    repeat (3) @(negedge clk);
    chk("R1 reset valid", DW'(rvalid_o), DW'(0));
    chk("R1 reset data", rdata_o, '0);
    chk("R9 reset oe", DW'(dq_oe_o), DW'(0));
    rst_ni = 1'b1;

    // full fill then full readback
    for (int a = 0; a < 256; a++) tick(1'b0, 1'b1, 3'b010, AW'(a), '1, pat(a, 0), "R2 fill");
    for (int a = 0; a < 256; a++) tick(1'b0, 1'b0, 3'b010, AW'(a), '0, '0, "R1 read");

    // every byte-enable pattern
    for (int a = 0; a < 16; a++) tick(1'b0, 1'b1, 3'b010, AW'(a), NB'(a), pat(a, 5), "R2 be");
    for (int a = 0; a < 16; a++) tick(1'b0, 1'b0, 3'b010, AW'(a), '0, '0, "R2 be read");

    // write/read alternating each cycle, read right behind its write
    for (int i = 0; i < 32; i++) begin
      tick(1'b0, 1'b1, 3'b010, AW'(64 + i), NB'(i + 1), pat(i, 9), "R3 wr");
      tick(1'b0, 1'b0, 3'b010, AW'(64 + i), '0, '0, "R3 fwd read");
    end
    for (int i = 0; i < 8; i++) begin
      tick(1'b0, 1'b0, 3'b010, AW'(100 + i), '0, '0, "R3 rd");
      tick(1'b0, 1'b1, 3'b010, AW'(100 + i), '1, pat(i, 11), "R3 wr after rd");
    end
    for (int i = 0; i < 8; i++) tick(1'b0, 1'b0, 3'b010, AW'(100 + i), '0, '0, "R3 readback");

    // every chip-select pattern on reads and writes
    for (int c = 0; c < 8; c++) begin
      tick(1'b0, 1'b1, 3'(c), 8'd200, '1, pat(c, 17), "R5 cs write");
      tick(1'b0, 1'b0, 3'(c), 8'd201, '0, '0, "R5 cs read");
      tick(1'b0, 1'b0, 3'b010, 8'd200, '0, '0, "R5 cs check");
    end

    // bursts: read order over fill data, write bursts then single readback
    for (int l = 0; l < 2; l++) begin
      for (int s = 0; s < 4; s++) begin
        idle(2);
        lin_i = 1'(l);
        tick(1'b0, 1'b0, 3'b010, AW'(32 + 4 * s + s), '0, '0, l ? "R8 rd beat" : "R7 rd beat");
        for (int n = 1; n < 6; n++)
          tick(1'b1, 1'b1, 3'b101, '0, '1, '0, l ? "R8 rd beat" : "R7 rd beat");
        tick(1'b0, 1'b1, 3'b010, AW'(160 + 8 * s + 4 * l + s), '1, pat(s, 40 + l), "R6 wr beat");
        for (int n = 1; n < 4; n++)
          tick(1'b1, 1'b0, 3'b111, '0, NB'(n * 5), pat(s + n, 40 + l), "R6 wr beat");
        for (int k = 0; k < 4; k++)
          tick(1'b0, 1'b0, 3'b010, AW'(160 + 8 * s + 4 * l + k), '0, '0,
               l ? "R8 wr readback" : "R7 wr readback");
      end
    end
    // burst behind a deselected load stays idle
    tick(1'b0, 1'b1, 3'b011, 8'd220, '1, pat(1, 50), "R6 desel load");
    for (int n = 1; n < 4; n++) tick(1'b1, 1'b1, 3'b010, '0, '1, pat(n, 50), "R6 desel beat");
    for (int k = 0; k < 4; k++) tick(1'b0, 1'b0, 3'b010, AW'(220 + k), '0, '0, "R6 desel check");

    // suspended edges hold outputs and delay write data
    tick(1'b0, 1'b1, 3'b010, 8'd10, 4'b1010, pat(2, 60), "R4 wr");
    tick(1'b0, 1'b0, 3'b010, 8'd11, '0, '0, "R4 rd");
    stall(3);
    tick(1'b0, 1'b0, 3'b010, 8'd12, '0, '0, "R4 rd");
    stall(2);
    tick(1'b0, 1'b0, 3'b010, 8'd10, '0, '0, "R4 delayed data");
    idle(1);

    // output enable and sleep gate the drivers without disturbing the pipeline
    tick(1'b0, 1'b0, 3'b010, 8'd3, '0, '0, "R9 rd");
    tick(1'b0, 1'b0, 3'b111, '0, '0, '0, "R9 idle");
    stall(1);
    chk("R9 visible", rdata_o, mdl[3]);
    oe_i = 1'b0; #1;
    chk("R9 oe off drive", DW'(dq_oe_o), DW'(0));
    chk("R9 oe off data", rdata_o, '0);
    oe_i = 1'b1; #1;
    chk("R9 oe back", rdata_o, mdl[3]);
    sleep_i = 1'b1; #1;
    chk("R10 sleep drive", DW'(dq_oe_o), DW'(0));
    chk("R10 sleep data", rdata_o, '0);
    sleep_i = 1'b0; #1;
    chk("R10 wake", rdata_o, mdl[3]);
    idle(2);

    // commands while asleep are deselects
    sleep_i = 1'b1;
    tick(1'b0, 1'b1, 3'b010, 8'd4, '1, pat(4, 70), "R10 sleep wr");
    tick(1'b0, 1'b0, 3'b010, 8'd4, '0, '0, "R10 sleep rd");
    tick(1'b1, 1'b0, 3'b010, '0, '0, '0, "R10 sleep adv");
    sleep_i = 1'b0;
    idle(1);
    tick(1'b0, 1'b0, 3'b010, 8'd4, '0, '0, "R10 retained");
    idle(2);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule